// File: doc/BRIEF.md
# Stereo PCM soft mute with zero-run flag

This block sits in the digital audio path ahead of a converter and fades a stereo PCM stream to silence and back. A frame strobe marks each sample period; on that strobe the block takes one left and one right sample. It multiplies each by a linear gain coefficient and registers the result. A mute request walks the gain down one step at a time to zero, and releasing the request walks it back up to unity. The request can be raised or dropped at any point of a ramp, and the gain then turns around from wherever it stands, with no jump.

The step pace follows a speed-mode select, so the ramp lasts a fixed number of frames for each rate: one step per frame at the base rate, one every second frame at double rate and one every fourth frame at quad rate. A ramp controller state machine labels the gain's situation with four states. UNITY holds full gain. FALL is a descent under an active request. SILENT holds zero gain. RISE is a climb after release. The named transitions are UNITY→FALL (request raised), FALL→SILENT (last step down), FALL→RISE and SILENT→RISE (request dropped), RISE→FALL (request raised again) and RISE→UNITY (last step up).

Beside the ramp, a watcher raises a flag once both channels have carried zero for a long unbroken run of frames. It drops the flag on the first frame in which either channel is non-zero.

Top module: `snd_soft_mute`

## Requirements
- R1: While reset is asserted, and at the first clock after it, `out_l`, `out_r` and `zero_flag` are 0. Reset sets the gain to unity, which is 1024 on a scale where 1024 passes a sample unchanged.
- R2: At each clock edge where `frame_stb` is 1, each output is loaded with its channel's input multiplied by the gain in force before that strobe's step, divided by 1024, and rounded toward zero. The new value is visible from the next cycle.
- R3: While the gain is at unity, each output equals its channel's input sample exactly.
- R4: The request `mute_req` is sampled only on strobes. On a step with the request at 1, a non-zero gain drops by exactly one. After 1024 steps the gain is 0 and both outputs are 0.
- R5: On a step with the request at 0, a gain below 1024 rises by exactly one, and it stays at 1024 once it gets there.
- R6: `speed_mode` 2'b00 steps on every strobe. 2'b01 steps on every second strobe counted from reset (strobes 2, 4, …). 2'b10 and 2'b11 step on every fourth strobe (strobes 4, 8, …). A full ramp therefore spans 1024, 2048 or 4096 frames.
- R7: When the request changes partway through a ramp, the gain moves from its current value toward the new target on the next step. It changes by at most one per step.
- R8: `zero_flag` goes to 1 in the cycle after the 8192nd consecutive strobe on which both `smp_l` and `smp_r` are zero, and stays at 1 while the zero run continues.
- R9: A strobe on which either channel is non-zero clears `zero_flag` from the next cycle and restarts the zero run count.
- R10: Sample and request values present on cycles without a strobe have no effect: the outputs and `zero_flag` change only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame; samples and request are taken on it |
| speed_mode | input | 2 | Rate select: 00 base, 01 double, 10/11 quad |
| mute_req | input | 1 | 1 requests a fade to silence, 0 requests full level |
| smp_l | input | DATA_W (24) | Left signed input sample |
| smp_r | input | DATA_W (24) | Right signed input sample |
| out_l | output | DATA_W (24) | Left attenuated sample |
| out_r | output | DATA_W (24) | Right attenuated sample |
| zero_flag | output | 1 | Both channels have been zero for the full run length |

## Verification
Every result of this block is due one clock after the strobe edge that produced it: the scaled samples, the gain step and the zero flag. The gain step first shows in the outputs of the following strobe. The bench's reference model advances at that same rising edge, and every output is compared on the falling edge that follows, on every cycle, including the cycles between strobes where nothing may move. Directed checks read the outputs one full frame after their last strobe. The ramp-length and zero-run boundaries are counted in strobes from reset, so the check of the 8191st and the 8192nd zero frame falls on the exact frame boundary.

// File: rtl/snd_mute_pkg.sv
package snd_mute_pkg;

    typedef enum logic [1:0] {
        ST_UNITY  = 2'b00,
        ST_FALL   = 2'b01,
        ST_SILENT = 2'b10,
        ST_RISE   = 2'b11
    } ramp_state_t;

    typedef enum logic [1:0] {
        SPD_BASE   = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_B = 2'b11
    } speed_t;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/snd_mute_pacer.sv
module snd_mute_pacer
    import snd_mute_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic [1:0] speed_mode,
    output logic       step
);

    logic [1:0] phase_q;
    logic       hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
        end else if (frame_stb) begin
            phase_q <= phase_q + 2'd1;
        end
    end

    always_comb begin
        unique case (speed_t'(speed_mode))
            SPD_BASE:   hit = 1'b1;
            SPD_DOUBLE: hit = phase_q[0];
            SPD_QUAD,
            SPD_QUAD_B: hit = &phase_q;
            default:    hit = 1'b1;
        endcase
    end

    assign step = frame_stb && hit;

endmodule

// File: rtl/snd_mute_ramp_fsm.sv
module snd_mute_ramp_fsm
    import snd_mute_pkg::*;
#(
    parameter int unsigned GAIN_W = 10,
    localparam int unsigned G_W   = GAIN_W + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_stb,
    input  logic           step,
    input  logic           mute_req,
    output logic [G_W-1:0] gain,
    output ramp_state_t    state
);

    localparam logic [G_W-1:0] G_FULL = G_W'(1) << GAIN_W;
    localparam logic [G_W-1:0] G_ZERO = '0;

    ramp_state_t    state_q, state_d;
    logic [G_W-1:0] gain_q, gain_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNITY;
        end else begin
            state_q <= state_d;
        end
    end

    // output register: the gain coefficient
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= G_FULL;
        end else begin
            gain_q <= gain_d;
        end
    end

    // next gain: one step toward the target picked by the request
    always_comb begin
        gain_d = gain_q;
        if (step) begin
            if (mute_req && gain_q != G_ZERO) begin
                gain_d = gain_q - G_W'(1);
            end else if (!mute_req && gain_q != G_FULL) begin
                gain_d = gain_q + G_W'(1);
            end
        end
    end

    // next state: evaluated once per frame
    always_comb begin
        state_d = state_q;
        if (frame_stb) begin
            unique case (state_q)
                ST_UNITY: begin
                    if (mute_req) state_d = ST_FALL;
                end
                ST_FALL: begin
                    if (!mute_req)              state_d = ST_RISE;
                    else if (gain_d == G_ZERO)  state_d = ST_SILENT;
                end
                ST_SILENT: begin
                    if (!mute_req) state_d = ST_RISE;
                end
                ST_RISE: begin
                    if (mute_req)               state_d = ST_FALL;
                    else if (gain_d == G_FULL)  state_d = ST_UNITY;
                end
                default: state_d = ST_UNITY;
            endcase
        end
    end

    assign gain  = gain_q;
    assign state = state_q;

endmodule

// File: rtl/snd_mute_scaler.sv
module snd_mute_scaler #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned GAIN_W = 10,
    localparam int unsigned G_W    = GAIN_W + 1,
    localparam int unsigned PROD_W = DATA_W + GAIN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] smp,
    input  logic [G_W-1:0]    gain,
    output logic [DATA_W-1:0] smp_out
);

    localparam logic signed [PROD_W-1:0] TRUNC_BIAS = PROD_W'((64'd1 << GAIN_W) - 64'd1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic                     unused_bits;

    always_comb begin
        prod   = $signed(smp) * $signed({1'b0, gain});
        // bias negative products so the shift rounds toward zero
        biased = prod[PROD_W-1] ? prod + TRUNC_BIAS : prod;
    end

    assign unused_bits = ^{biased[PROD_W-1:GAIN_W+DATA_W], biased[GAIN_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_out <= '0;
        end else if (frame_stb) begin
            smp_out <= biased[GAIN_W +: DATA_W];
        end
    end

endmodule

// File: rtl/snd_zero_watch.sv
module snd_zero_watch
    import snd_mute_pkg::*;
#(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned ZERO_RUN = 8192,
    localparam int unsigned CNT_W   = $clog2(ZERO_RUN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] smp_a,
    input  logic [DATA_W-1:0] smp_b,
    output logic              zero_flag
);

    localparam logic [CNT_W-1:0] RUN_END  = CNT_W'(ZERO_RUN);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(ZERO_RUN - 1);

    logic [CNT_W-1:0] run_q;
    logic             both_zero;

    assign both_zero = (smp_a == '0) && (smp_b == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            zero_flag <= 1'b0;
        end else if (frame_stb) begin
            if (!both_zero) begin
                run_q     <= '0;
                zero_flag <= 1'b0;
            end else begin
                if (run_q != RUN_END) begin
                    run_q <= run_q + CNT_W'(1);
                end
                zero_flag <= (run_q >= RUN_LAST);
            end
        end
    end

endmodule

// File: rtl/snd_soft_mute.sv
module snd_soft_mute
    import snd_mute_pkg::*;
#(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned GAIN_W   = 10,
    parameter int unsigned ZERO_RUN = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [1:0]        speed_mode,
    input  logic              mute_req,
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              zero_flag
);

    localparam int unsigned G_W = GAIN_W + 1;

    logic                step_tick;
    logic [G_W-1:0]      gain_q;
    ramp_state_t         ramp_state;
    logic [DATA_W-1:0]   ch_in  [NUM_CH];
    logic [DATA_W-1:0]   ch_out [NUM_CH];

    assign ch_in[0] = smp_l;
    assign ch_in[1] = smp_r;

    snd_mute_pacer u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .speed_mode (speed_mode),
        .step       (step_tick)
    );

    snd_mute_ramp_fsm #(.GAIN_W(GAIN_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .step      (step_tick),
        .mute_req  (mute_req),
        .gain      (gain_q),
        .state     (ramp_state)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        snd_mute_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_stb (frame_stb),
            .smp       (ch_in[ch]),
            .gain      (gain_q),
            .smp_out   (ch_out[ch])
        );
    end

    snd_zero_watch #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_zero (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .smp_a     (smp_l),
        .smp_b     (smp_r),
        .zero_flag (zero_flag)
    );

    assign out_l = ch_out[0];
    assign out_r = ch_out[1];

endmodule

// File: rtl/snd_soft_mute_chk.sv
module snd_soft_mute_chk
    import snd_mute_pkg::*;
#(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned GAIN_W = 10,
    localparam int unsigned G_W   = GAIN_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic              mute_req,
    input logic [DATA_W-1:0] smp_l,
    input logic [DATA_W-1:0] smp_r,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r,
    input logic              zero_flag,
    input logic              step,
    input logic [G_W-1:0]    gain,
    input ramp_state_t       state
);

    localparam logic [G_W-1:0] G_FULL = G_W'(1) << GAIN_W;

    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= G_FULL);                                                    // R4

    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(gain));                                           // R6

    AST_MUTE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mute_req && gain != '0) |=> gain == $past(gain) - G_W'(1)); // R4

    AST_RELEASE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mute_req && gain != G_FULL) |=> gain == $past(gain) + G_W'(1)); // R7

    AST_SILENT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && gain == '0) |=> (out_l == '0 && out_r == '0));       // R4

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && gain == G_FULL) |=> (out_l == $past(smp_l) && out_r == $past(smp_r))); // R3

    AST_STATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SILENT |-> gain == '0);                                 // R4

    AST_STATE_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_UNITY |-> gain == G_FULL);                              // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(out_l) && $stable(out_r) && $stable(zero_flag))); // R10

    AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && (smp_l != '0 || smp_r != '0)) |=> !zero_flag);       // R9

endmodule

bind snd_soft_mute snd_soft_mute_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .mute_req  (mute_req),
    .smp_l     (smp_l),
    .smp_r     (smp_r),
    .out_l     (out_l),
    .out_r     (out_r),
    .zero_flag (zero_flag),
    .step      (step_tick),
    .gain      (gain_q),
    .state     (ramp_state)
);

// File: tb/test_snd_soft_mute.sv
module test_snd_soft_mute;

    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic [1:0]    speed_mode = 2'b00;
    logic          mute_req = 1'b0;
    logic [DW-1:0] smp_l = '0;
    logic [DW-1:0] smp_r = '0;
    logic [DW-1:0] out_l;
    logic [DW-1:0] out_r;
    logic          zero_flag;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;

    // reference model state
    int     m_gain;
    int     m_strobes;
    int     m_zrun;
    longint e_l, e_r;
    int     e_z;
    logic [DW-1:0] last_l, last_r;

    always #4 clk = ~clk;

    snd_soft_mute i_snd_soft_mute (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .speed_mode (speed_mode),
        .mute_req   (mute_req),
        .smp_l      (smp_l),
        .smp_r      (smp_r),
        .out_l      (out_l),
        .out_r      (out_r),
        .zero_flag  (zero_flag)
    );

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on the same edge as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gain = 1024; m_strobes = 0; m_zrun = 0;
            e_l = 0; e_r = 0; e_z = 0;
        end else if (frame_stb) begin
            bit do_step;
            e_l = (longint'($signed(smp_l)) * m_gain) / 1024;
            e_r = (longint'($signed(smp_r)) * m_gain) / 1024;
            m_strobes++;
            case (speed_mode)
                2'b00:   do_step = 1'b1;
                2'b01:   do_step = (m_strobes % 2) == 0;
                default: do_step = (m_strobes % 4) == 0;
            endcase
            if (do_step) begin
                if (mute_req && m_gain > 0) m_gain--;
                else if (!mute_req && m_gain < 1024) m_gain++;
            end
            if (smp_l == 0 && smp_r == 0) begin
                if (m_zrun < 8192) m_zrun++;
            end else begin
                m_zrun = 0;
            end
            e_z = (m_zrun >= 8192) ? 1 : 0;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R2 R10", longint'($signed(out_l)), e_l, "left output vs model");
            chk("R2 R10", longint'($signed(out_r)), e_r, "right output vs model");
            chk("R8", longint'(zero_flag), longint'(e_z), "zero flag vs model");
        end
    end

    // kind: 0 fixed, 1 random, 2 both zero, 3 left only, 4 right only
    task automatic frames(input int n, input bit mute, input int kind);
        for (int f = 0; f < n; f++) begin
            @(negedge clk);
            frame_stb = 1'b1;
            mute_req  = mute;
            case (kind)
                0: begin smp_l = 24'h300000; smp_r = 24'hC12345; end
                1: begin smp_l = DW'($urandom); smp_r = DW'($urandom); end
                2: begin smp_l = '0; smp_r = '0; end
                3: begin smp_l = 24'h000005; smp_r = '0; end
                default: begin smp_l = '0; smp_r = 24'hFFFFF0; end
            endcase
            last_l = smp_l; last_r = smp_r;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                frame_stb = 1'b0;
                mute_req  = 1'($urandom);
                smp_l     = DW'($urandom);
                smp_r     = DW'($urandom);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", longint'(out_l), 0, "left in reset");
        chk("R1", longint'(out_r), 0, "right in reset");
        chk("R1", longint'(zero_flag), 0, "zero flag in reset");
        compare_on = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", longint'(out_l | out_r), 0, "outputs after reset");

        // base rate, unity gain: passthrough
        speed_mode = 2'b00;
        frames(1, 1'b0, 0);
        chk("R3", longint'(out_l), longint'(last_l), "unity left");
        chk("R3", longint'(out_r), longint'(last_r), "unity right");
        frames(20, 1'b0, 1);

        // fade to silence at base rate
        frames(1100, 1'b1, 1);
        frames(1, 1'b1, 0);
        chk("R4", longint'(out_l), 0, "silent left");
        chk("R4", longint'(out_r), 0, "silent right");

        // release back to unity
        frames(1100, 1'b0, 1);
        frames(1, 1'b0, 0);
        chk("R5", longint'(out_l), longint'(last_l), "restored left");
        chk("R5", longint'(out_r), longint'(last_r), "restored right");

        // double rate: ramp takes twice the frames
        speed_mode = 2'b01;
        frames(1500, 1'b1, 1);
        frames(1, 1'b1, 0);
        chk("R6", longint'(out_l != 0), 1, "double rate still audible at 1500 frames");
        frames(700, 1'b1, 1);
        frames(1, 1'b1, 0);
        chk("R6", longint'(out_l), 0, "double rate silent after 2200 frames");
        frames(2100, 1'b0, 1);
        frames(1, 1'b0, 0);
        chk("R5", longint'(out_r), longint'(last_r), "double rate restored");

        // quad rate, reversal mid-ramp
        speed_mode = 2'b10;
        frames(400, 1'b1, 0);
        frames(8, 1'b0, 0);
        chk("R7", longint'($signed(out_l) < $signed(last_l)), 1, "reversal below unity");
        chk("R7", longint'($signed(out_l) > 24'sh280000), 1, "reversal no jump to silence");
        speed_mode = 2'b11;
        frames(420, 1'b0, 1);
        frames(1, 1'b0, 0);
        chk("R7", longint'(out_l), longint'(last_l), "reversal reaches unity");

        // zero run
        frames(8191, 1'b0, 2);
        chk("R8", longint'(zero_flag), 0, "flag low after 8191 zero frames");
        frames(1, 1'b0, 2);
        chk("R8", longint'(zero_flag), 1, "flag high after 8192 zero frames");
        frames(5, 1'b0, 2);
        chk("R8", longint'(zero_flag), 1, "flag held during run");
        frames(1, 1'b0, 3);
        chk("R9", longint'(zero_flag), 0, "left non-zero clears flag");
        frames(8192, 1'b0, 2);
        chk("R9", longint'(zero_flag), 1, "run restarted and completed");
        frames(1, 1'b0, 4);
        chk("R9", longint'(zero_flag), 0, "right non-zero clears flag");

        compare_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule